// File: doc/BRIEF.md
# Strobed Bus Input Port Latch

This block brings a byte from a peripheral onto a shared processor data bus. A level-sensitive storage register sits between the peripheral's data lines and the bus. While the strobe input is high, the register is transparent and follows the input. When the strobe drops, the register keeps the last value it saw. An active-low clear empties the register, but only while the strobe is low. A clear that arrives during a strobe is ignored. If the clear is still low when the strobe ends, the register clears at that moment.

Two select inputs decide whether the port drives the bus. A parameter sets the select polarity. In one mode the first select is active low and the second is active high. In the other mode both are active high. When the select condition is not met, the bus pins are released to high impedance so that other devices can drive the bus. Selection only gates the drivers. It never changes what is stored.

Top module: `strobe_in_port`

## Requirements
- R1: With the strobe high and the port selected, the bus shows the data input, and it follows every change of that input (default width 8 bits).
- R2: When the strobe falls, the value present on the data input at that moment is kept. Later changes of the data input do not reach the bus while the strobe stays low.
- R3: With the strobe low, rst_ni low clears the register to all zeros, and the bus reads 0 when selected.
- R4: Driving rst_ni low while the strobe is high has no effect: the bus keeps following the data input.
- R5: If rst_ni is still low when the strobe falls, the register becomes all zeros right after the fall.
- R6: When the port is not selected it does not drive the bus, so a value placed on the bus by another driver reads back unchanged.
- R7: With SEL_MODE = SEL_LOW_HIGH (default), the port is selected exactly when sel_a_i = 0 and sel_b_i = 1. The other three combinations float the bus.
- R8: With SEL_MODE = SEL_HIGH_HIGH, the port is selected exactly when sel_a_i = 1 and sel_b_i = 1. The other three combinations float the bus.
- R9: Deselecting and then reselecting the port leaves the stored value unchanged. The bus shows the held value again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din_i | input | WIDTH | Data from the peripheral |
| strobe_i | input | 1 | High: register transparent. Falling edge: register holds |
| rst_ni | input | 1 | Active-low clear, honoured only while the strobe is low |
| sel_a_i | input | 1 | First select. Polarity is set by SEL_MODE |
| sel_b_i | input | 1 | Second select, always active high |
| dout_io | inout | WIDTH | Bus output. High impedance when not selected |

## Verification
The data path is driven in several ways:
- the data input changes while the strobe is high, which separates a transparent register from an edge-triggered one;
- the data input changes after the strobe has fallen, which separates holding from following;
- clear pulses arrive both inside and outside the strobe window, and one clear is held across the strobe fall, which tells gated clearing apart from ungated and from lost clearing.

All four select combinations are tried in both polarity modes while a bench driver shares the bus. This shows whether the port really releases the bus. Long random sequences then mix all of these inputs against a bench model of latch behaviour.

// File: rtl/strobe_port_pkg.sv
package strobe_port_pkg;
  typedef enum logic {
    SEL_LOW_HIGH  = 1'b0,
    SEL_HIGH_HIGH = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/port_sel_decode.sv
module port_sel_decode #(
  parameter strobe_port_pkg::sel_mode_e SEL_MODE = strobe_port_pkg::SEL_LOW_HIGH
) (
  input  logic sel_a_i,
  input  logic sel_b_i,
  output logic drive_en_o
);
  generate
    if (SEL_MODE == strobe_port_pkg::SEL_LOW_HIGH) begin : g_low_high
      assign drive_en_o = ~sel_a_i & sel_b_i;
    end else begin : g_high_high
      assign drive_en_o = sel_a_i & sel_b_i;
    end
  endgenerate
endmodule

// File: rtl/port_data_latch.sv
module port_data_latch #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] din_i,
  input  logic             strobe_i,
  input  logic             rst_ni,
  output logic [WIDTH-1:0] q_o
);
  // strobe has priority: a clear only lands once the strobe is low
  always_latch begin
    if (strobe_i)     q_o = din_i;
    else if (!rst_ni) q_o = '0;
  end

  // just before the strobe falls, the register must equal the input
  assert_transparent_R1: assert property (@(negedge strobe_i) disable iff (!rst_ni)
    q_o == din_i);

  // when a clear is released after acting with the strobe low, the register is zero
  assert_clear_R3: assert property (@(posedge rst_ni) disable iff (!rst_ni)
    !strobe_i |-> q_o == '0);
endmodule

// File: rtl/strobe_in_port.sv
module strobe_in_port #(
  parameter int                         WIDTH    = 8,
  parameter strobe_port_pkg::sel_mode_e SEL_MODE = strobe_port_pkg::SEL_LOW_HIGH
) (
  input  logic [WIDTH-1:0] din_i,
  input  logic             strobe_i,
  input  logic             rst_ni,
  input  logic             sel_a_i,
  input  logic             sel_b_i,
  inout  wire  [WIDTH-1:0] dout_io
);
  localparam logic [WIDTH-1:0] FLOAT = {WIDTH{1'bz}};

  logic [WIDTH-1:0] q;
  logic             drive_en;

  port_data_latch #(.WIDTH(WIDTH)) i_latch (
    .din_i   (din_i),
    .strobe_i(strobe_i),
    .rst_ni  (rst_ni),
    .q_o     (q)
  );

  port_sel_decode #(.SEL_MODE(SEL_MODE)) i_sel (
    .sel_a_i   (sel_a_i),
    .sel_b_i   (sel_b_i),
    .drive_en_o(drive_en)
  );

  assign dout_io = drive_en ? q : FLOAT;

  // while driving, the bus carried the stored value
  assert_bus_drive_R9: assert property (@(negedge drive_en) disable iff (!rst_ni)
    dout_io == q);

  // end to end: selected and transparent means bus equals input at strobe fall
  assert_bus_pass_R1: assert property (@(negedge strobe_i) disable iff (!rst_ni)
    drive_en |-> dout_io == din_i);
endmodule

// File: tb/test_strobe_in_port.sv
module test_strobe_in_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic [W-1:0] din = '0;
  logic         strobe = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_a = 1'b0;
  logic         sel_b = 1'b1;
  logic [W-1:0] pat = 8'h96;
  wire  [W-1:0] bus_lh;
  wire  [W-1:0] bus_hh;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [W-1:0] exp_q = '0;

  always #5 clk = ~clk;

  // selection computed from R7 / R8, independent of the design
  wire sel_lh = ~sel_a & sel_b;
  wire sel_hh = sel_a & sel_b;

  // bench plays the other bus device whenever the port must be off
  assign bus_lh = sel_lh ? {W{1'bz}} : pat;
  assign bus_hh = sel_hh ? {W{1'bz}} : pat;

  strobe_in_port #(.WIDTH(W)) i_strobe_in_port (
    .din_i(din), .strobe_i(strobe), .rst_ni(rst_n),
    .sel_a_i(sel_a), .sel_b_i(sel_b), .dout_io(bus_lh)
  );

  strobe_in_port #(.WIDTH(W), .SEL_MODE(strobe_port_pkg::SEL_HIGH_HIGH)) i_strobe_in_port_hh (
    .din_i(din), .strobe_i(strobe), .rst_ni(rst_n),
    .sel_a_i(sel_a), .sel_b_i(sel_b), .dout_io(bus_hh)
  );

  function automatic logic [W-1:0] next_q(logic [W-1:0] q, logic [W-1:0] d,
                                          logic stb, logic rn);
    if (stb) return d;
    if (!rn) return '0;
    return q;
  endfunction

  function automatic logic [W-1:0] exp_bus(logic sel, logic [W-1:0] q, logic [W-1:0] p);
    return sel ? q : p;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // data/clear/selects change at posedge, strobe 2 ns later, sample at negedge
  task automatic step(logic [W-1:0] d, logic stb, logic rn, logic sa, logic sb,
                      logic [W-1:0] p);
    @(posedge clk);
    din = d; rst_n = rn; sel_a = sa; sel_b = sb; pat = p;
    exp_q = next_q(exp_q, d, strobe, rn);
    #2;
    strobe = stb;
    exp_q = next_q(exp_q, d, stb, rn);
    @(negedge clk);
  endtask

  task automatic check_both(string req);
    check(req, bus_lh, exp_bus(sel_lh, exp_q, pat));
    check(req, bus_hh, exp_bus(sel_hh, exp_q, pat));
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    // R3: reset state, strobe low, clear low
    step(8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11);
    check("R3 reset lh", bus_lh, 8'h00);
    step(8'hEE, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11);
    check("R3 held zero", bus_lh, 8'h00);

    // R1: transparency
    step(8'hA5, 1'b1, 1'b1, 1'b0, 1'b1, 8'h11);
    check("R1 pass a5", bus_lh, 8'hA5);
    step(8'h3C, 1'b1, 1'b1, 1'b0, 1'b1, 8'h11);
    check("R1 follow 3c", bus_lh, 8'h3C);

    // R2: hold after fall
    step(8'h3C, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11);
    step(8'h77, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11);
    check("R2 hold", bus_lh, 8'h3C);

    // R4: clear ignored during strobe
    step(8'h5A, 1'b1, 1'b0, 1'b0, 1'b1, 8'h11);
    check("R4 clear ignored", bus_lh, 8'h5A);
    step(8'h6B, 1'b1, 1'b0, 1'b0, 1'b1, 8'h11);
    check("R4 still follows", bus_lh, 8'h6B);
    // R5: clear still low at strobe fall
    step(8'h6B, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11);
    check("R5 pending clear", bus_lh, 8'h00);

    // load a value to hold for select tests
    step(8'hC3, 1'b1, 1'b1, 1'b0, 1'b1, 8'h11);
    step(8'hC3, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11);

    // R6/R7: low-high mode, other combos float; R8: high-high mode
    step(8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 8'h4D);
    check("R7 lh a1b1 float", bus_lh, 8'h4D);
    check("R8 hh a1b1 drive", bus_hh, 8'hC3);
    step(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h2E);
    check("R6 lh a0b0 float", bus_lh, 8'h2E);
    check("R8 hh a0b0 float", bus_hh, 8'h2E);
    step(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'hB1);
    check("R7 lh a1b0 float", bus_lh, 8'hB1);
    check("R8 hh a1b0 float", bus_hh, 8'hB1);
    step(8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'hB1);
    check("R9 reselect held", bus_lh, 8'hC3);
    check("R8 hh a0b1 float", bus_hh, 8'hB1);

    // random mix against bench model
    for (int i = 0; i < 400; i++) begin
      step(W'($urandom), $urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0,
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, W'($urandom));
      check_both("R1 R2 R3 R4 R5 R6 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule